// File: doc/BRIEF.md
# Indexed-Colour Display Register Slave

This block is the register front end of an 8-bit indexed-colour display controller. A host reaches it over a simple synchronous bus with a 21-bit byte address. It accepts word, half-word and byte accesses. A narrow write is turned into a read-modify-write of the word that contains it.

The block holds the state the scanout engine consumes:
- a 256-entry RGB lookup table
- a three-colour cursor palette
- a 512-word cursor bitmap
- the control word, the scanout start address, the cursor location and the visible width and height.

The pixel pipeline reads the tables through its own lookup ports, which never collide with bus traffic. Video timing registers are decoded so that software can program them, but their contents are dropped. Scanout raises a frame event, which sets an interrupt. Any bus write lowers that interrupt again. One address acts as a soft reset for the whole block.

Top module: `pixctl_regs`

## Requirements
- R1: After rstN is released, all tables and registers read as zero on their pipeline ports, irq is low, and rdValid and errPulse are low.
- R2: rdValid rises exactly one cycle after rdEn, with rdData valid in the same cycle. The access size comes from byteEn:
  - 4'b1111 is a word access.
  - Exactly two strobes set is a half-word access, taking the upper half when addr[1] is 1.
  - Any other pattern is a byte access on lane addr[1:0].
  Read data is returned right-justified and zero-extended.
- R3: A read of address 0x000000 returns 0x10. Writes to 0x000000, 0x080000, 0x080108, 0x080110, 0x080120, 0x080128, 0x080130, 0x080138, 0x080140, 0x080148, 0x080158, 0x080160, 0x080168, 0x080170 and 0x080200 change no state and raise no error.
- R4: Colour table:
  - The region 0x080800–0x080FFF is the colour table, and the entry index is addr[10:3].
  - Each entry stores red from data bits 23:16, green from 15:8 and blue from 7:0.
  - The entry appears on palRgb (same packing) for the index on palIdx.
  - A bus read of the region returns zero and flags an error.
- R5: Cursor palette:
  - The region 0x080508–0x08051F is the cursor palette, with entry (addr − 0x080508) >> 3 and the same packing as R4.
  - Entries are readable over the bus.
  - cpalRgb shows the entry chosen by cpalSel, and shows zero when cpalSel is 3.
- R6: Cursor bitmap:
  - The region 0x081000–0x081FFF is the cursor bitmap, with word index addr[11:3].
  - A write stores data bits 15:0.
  - A read returns the word zero-extended.
  - cpatWord shows the word selected by cpatIdx.
- R7: Width and height scaling:
  - A write of v to 0x080118 sets widthPx to (v × 4) mod 2^DIM_W, and a read there returns widthPx / 4.
  - A write of v to 0x080150 sets heightPx to (v / 2) mod 2^DIM_W, and a read there returns heightPx × 2.
- R8: Control word:
  - The control word at 0x080300 is read/write and appears on ctrlReg.
  - ctrlReg bits 22:20 give depthBpp for codes 0..7 as 1, 2, 4, 8, 15, 16, 0, 0.
  - forceBlank is bit 10 and cursorOff is bit 23.
  - The control word changes only on a bus write.
- R9: Address 0x080400 (topOfScreen) and address 0x080638 (cursorPos) are write-only. Reads there return zero and flag an error.
- R10: A narrow write places its right-justified data in the lane chosen as in R2. The other lanes keep the word's current read value, which is zero for write-only locations; this applies to width and height too.
- R11: A frameTick sets irq on the next edge. Any bus write, decoded or not, clears irq on the next edge, and the clear wins over a simultaneous tick.
- R12: A write to 0x180000 clears every table, cursor colour, control, start address, cursor location, width, height and irq.
- R13: Errors and unmapped addresses:
  - Reads of unmapped or write-only addresses return zero.
  - Writes to unmapped addresses change nothing.
  - In both cases errPulse is high for exactly the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 21 | Byte address of the access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| byteEn | input | 4 | Strobes giving the access size |
| wrData | input | 32 | Right-justified write data |
| rdData | output | 32 | Right-justified read data |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| errPulse | output | 1 | Access to an address with no such access |
| frameTick | input | 1 | Frame event from scanout |
| irq | output | 1 | Interrupt request |
| palIdx | input | PAL_AW | Colour table lookup index |
| palRgb | output | 24 | Colour table entry |
| cpalSel | input | 2 | Cursor colour select |
| cpalRgb | output | 24 | Cursor colour |
| cpatIdx | input | CPAT_AW | Cursor bitmap word index |
| cpatWord | output | 16 | Cursor bitmap word |
| ctrlReg | output | 32 | Control word |
| depthBpp | output | 5 | Decoded bits per pixel, zero if invalid |
| forceBlank | output | 1 | Blank the display |
| cursorOff | output | 1 | Hide the cursor |
| topOfScreen | output | 32 | Scanout start address |
| cursorPos | output | 32 | Cursor location |
| widthPx | output | DIM_W | Visible width in pixels |
| heightPx | output | DIM_W | Visible height in lines |

## Verification
The assertions watch the following on every cycle:
- read latency;
- zero data on flagged reads;
- the absence of errors without an access;
- the write-clears-interrupt rule and its priority over frame events;
- four-pixel alignment of the width;
- legal depth codes;
- the control word holding still without writes;
- the soft reset's effect.

Only the bench scenarios show the contents of the stored state: the per-entry packing of both palettes and the bitmap, the arithmetic of the width and height scaling, lane selection and merging for narrow accesses, and the silent acceptance of timing addresses. They do so by sweeping every table entry and comparing against arithmetic expectations.

// File: rtl/pixctl_regs_pkg.sv
package pixctl_regs_pkg;
  localparam logic [20:0] ADR_ID     = 21'h000000;
  localparam logic [20:0] ADR_WIDTH  = 21'h080118;
  localparam logic [20:0] ADR_HEIGHT = 21'h080150;
  localparam logic [20:0] ADR_CTRL   = 21'h080300;
  localparam logic [20:0] ADR_TOP    = 21'h080400;
  localparam logic [20:0] ADR_CPAL   = 21'h080508;
  localparam logic [20:0] ADR_CPOS   = 21'h080638;
  localparam logic [20:0] ADR_PAL    = 21'h080800;
  localparam logic [20:0] ADR_CPAT   = 21'h081000;
  localparam logic [20:0] ADR_SRST   = 21'h180000;
  localparam logic [31:0] ID_VALUE   = 32'h0000_0010;
  localparam int          IDX_W      = 9;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_IGN, SEL_WIDTH, SEL_HEIGHT, SEL_CTRL,
    SEL_TOP, SEL_CPOS, SEL_CPAL, SEL_PAL, SEL_CPAT, SEL_SRST
  } regSelT;

  typedef struct packed {
    regSelT           sel;
    logic             doWr;
    logic             doRd;
    logic [IDX_W-1:0] idx;
    logic [4:0]       shift;
    logic [31:0]      laneMask;
  } strobeT;
endpackage

// File: rtl/pixctl_regs_decode.sv
module pixctl_regs_decode
  import pixctl_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [20:0] addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  byteEn,
  output strobeT      stb,
  output logic        rdValid,
  output logic        errPulse
);
  logic [20:0] wordAddr;
  logic [20:0] cOff;
  logic        readable;

  assign wordAddr = {addr[20:2], 2'b00};
  assign cOff     = wordAddr - ADR_CPAL;

  always_comb begin
    stb.sel  = SEL_NONE;
    stb.idx  = '0;
    stb.doWr = wrEn;
    stb.doRd = rdEn;
    if (wordAddr[20:12] == ADR_CPAT[20:12]) begin
      stb.sel = SEL_CPAT;
      stb.idx = wordAddr[11:3];
    end else if (wordAddr[20:11] == ADR_PAL[20:11]) begin
      stb.sel = SEL_PAL;
      stb.idx = {1'b0, wordAddr[10:3]};
    end else if (wordAddr >= ADR_CPAL && wordAddr < ADR_CPAL + 21'd24) begin
      stb.sel = SEL_CPAL;
      stb.idx = {{(IDX_W-2){1'b0}}, cOff[4:3]};
    end else begin
      case (wordAddr)
        ADR_ID:     stb.sel = SEL_ID;
        ADR_WIDTH:  stb.sel = SEL_WIDTH;
        ADR_HEIGHT: stb.sel = SEL_HEIGHT;
        ADR_CTRL:   stb.sel = SEL_CTRL;
        ADR_TOP:    stb.sel = SEL_TOP;
        ADR_CPOS:   stb.sel = SEL_CPOS;
        ADR_SRST:   stb.sel = SEL_SRST;
        21'h080000, 21'h080108, 21'h080110, 21'h080120, 21'h080128,
        21'h080130, 21'h080138, 21'h080140, 21'h080148, 21'h080158,
        21'h080160, 21'h080168, 21'h080170, 21'h080200:
                    stb.sel = SEL_IGN;
        default:    stb.sel = SEL_NONE;
      endcase
    end
    if (byteEn == 4'hF) begin
      stb.shift    = 5'd0;
      stb.laneMask = 32'hFFFF_FFFF;
    end else if ($countones(byteEn) == 2) begin
      stb.shift    = {addr[1], 4'b0000};
      stb.laneMask = 32'h0000_FFFF << stb.shift;
    end else begin
      stb.shift    = {addr[1:0], 3'b000};
      stb.laneMask = 32'h0000_00FF << stb.shift;
    end
  end

  assign readable = (stb.sel == SEL_ID) || (stb.sel == SEL_WIDTH) ||
                    (stb.sel == SEL_HEIGHT) || (stb.sel == SEL_CTRL) ||
                    (stb.sel == SEL_CPAL) || (stb.sel == SEL_CPAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      rdValid  <= rdEn;
      errPulse <= (rdEn && !readable) || (wrEn && stb.sel == SEL_NONE);
    end
  end
endmodule

// File: rtl/pixctl_regs_store.sv
module pixctl_regs_store
  import pixctl_regs_pkg::*;
#(
  parameter int PAL_DEPTH  = 256,
  parameter int CPAT_DEPTH = 512,
  parameter int DIM_W      = 16,
  localparam int PAL_AW  = $clog2(PAL_DEPTH),
  localparam int CPAT_AW = $clog2(CPAT_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [31:0]        wrData,
  input  logic               frameTick,
  input  logic [PAL_AW-1:0]  palIdx,
  input  logic [1:0]         cpalSel,
  input  logic [CPAT_AW-1:0] cpatIdx,
  output logic [31:0]        rdData,
  output logic               irq,
  output logic [23:0]        palRgb,
  output logic [23:0]        cpalRgb,
  output logic [15:0]        cpatWord,
  output logic [31:0]        ctrlReg,
  output logic [4:0]         depthBpp,
  output logic [31:0]        topOfScreen,
  output logic [31:0]        cursorPos,
  output logic [DIM_W-1:0]   widthPx,
  output logic [DIM_W-1:0]   heightPx
);
  logic [23:0] palMem  [PAL_DEPTH];
  logic [15:0] cpatMem [CPAT_DEPTH];
  logic [23:0] cpalMem [3];
  logic [31:0] wordVal, laneData, merged, wScaled, hScaled;
  logic        srstHit;

  assign srstHit = stb.doWr && stb.sel == SEL_SRST;

  always_comb begin
    case (stb.sel)
      SEL_ID:     wordVal = ID_VALUE;
      SEL_WIDTH:  wordVal = {{(32-DIM_W){1'b0}}, widthPx} >> 2;
      SEL_HEIGHT: wordVal = {{(31-DIM_W){1'b0}}, heightPx, 1'b0};
      SEL_CTRL:   wordVal = ctrlReg;
      SEL_CPAL:   wordVal = (stb.idx[1:0] < 2'd3) ? {8'h00, cpalMem[stb.idx[1:0]]} : 32'h0;
      SEL_CPAT:   wordVal = {16'h0000, cpatMem[stb.idx[CPAT_AW-1:0]]};
      default:    wordVal = 32'h0;
    endcase
  end

  assign laneData = wrData << stb.shift;
  assign merged   = (wordVal & ~stb.laneMask) | (laneData & stb.laneMask);
  assign wScaled  = merged << 2;
  assign hScaled  = merged >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_DEPTH; i++) palMem[i] <= '0;
      for (int i = 0; i < CPAT_DEPTH; i++) cpatMem[i] <= '0;
      for (int i = 0; i < 3; i++) cpalMem[i] <= '0;
      ctrlReg <= '0; topOfScreen <= '0; cursorPos <= '0;
      widthPx <= '0; heightPx <= '0; irq <= 1'b0; rdData <= '0;
    end else begin
      if (stb.doRd) rdData <= (wordVal & stb.laneMask) >> stb.shift;
      if (stb.doWr) irq <= 1'b0;
      else if (frameTick) irq <= 1'b1;
      if (srstHit) begin
        for (int i = 0; i < PAL_DEPTH; i++) palMem[i] <= '0;
        for (int i = 0; i < CPAT_DEPTH; i++) cpatMem[i] <= '0;
        for (int i = 0; i < 3; i++) cpalMem[i] <= '0;
        ctrlReg <= '0; topOfScreen <= '0; cursorPos <= '0;
        widthPx <= '0; heightPx <= '0;
      end else if (stb.doWr) begin
        case (stb.sel)
          SEL_WIDTH:  widthPx <= wScaled[DIM_W-1:0];
          SEL_HEIGHT: heightPx <= hScaled[DIM_W-1:0];
          SEL_CTRL:   ctrlReg <= merged;
          SEL_TOP:    topOfScreen <= merged;
          SEL_CPOS:   cursorPos <= merged;
          SEL_PAL:    if (32'(stb.idx) < PAL_DEPTH) palMem[stb.idx[PAL_AW-1:0]] <= merged[23:0];
          SEL_CPAT:   if (32'(stb.idx) < CPAT_DEPTH) cpatMem[stb.idx[CPAT_AW-1:0]] <= merged[15:0];
          SEL_CPAL:   if (stb.idx[1:0] < 2'd3) cpalMem[stb.idx[1:0]] <= merged[23:0];
          default: ;
        endcase
      end
    end
  end

  assign palRgb   = palMem[palIdx];
  assign cpatWord = cpatMem[cpatIdx];
  assign cpalRgb  = (cpalSel == 2'd3) ? 24'h0 : cpalMem[cpalSel];

  always_comb begin
    case (ctrlReg[22:20])
      3'd0: depthBpp = 5'd1;
      3'd1: depthBpp = 5'd2;
      3'd2: depthBpp = 5'd4;
      3'd3: depthBpp = 5'd8;
      3'd4: depthBpp = 5'd15;
      3'd5: depthBpp = 5'd16;
      default: depthBpp = 5'd0;
    endcase
  end
endmodule

// File: rtl/pixctl_regs.sv
module pixctl_regs
  import pixctl_regs_pkg::*;
#(
  parameter int PAL_DEPTH  = 256,
  parameter int CPAT_DEPTH = 512,
  parameter int DIM_W      = 16,
  localparam int PAL_AW  = $clog2(PAL_DEPTH),
  localparam int CPAT_AW = $clog2(CPAT_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [20:0]        addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [3:0]         byteEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               rdValid,
  output logic               errPulse,
  input  logic               frameTick,
  output logic               irq,
  input  logic [PAL_AW-1:0]  palIdx,
  output logic [23:0]        palRgb,
  input  logic [1:0]         cpalSel,
  output logic [23:0]        cpalRgb,
  input  logic [CPAT_AW-1:0] cpatIdx,
  output logic [15:0]        cpatWord,
  output logic [31:0]        ctrlReg,
  output logic [4:0]         depthBpp,
  output logic               forceBlank,
  output logic               cursorOff,
  output logic [31:0]        topOfScreen,
  output logic [31:0]        cursorPos,
  output logic [DIM_W-1:0]   widthPx,
  output logic [DIM_W-1:0]   heightPx
);
  strobeT stb;

  pixctl_regs_decode u_decode (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .byteEn(byteEn), .stb(stb), .rdValid(rdValid), .errPulse(errPulse)
  );

  pixctl_regs_store #(.PAL_DEPTH(PAL_DEPTH), .CPAT_DEPTH(CPAT_DEPTH), .DIM_W(DIM_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .frameTick(frameTick),
    .palIdx(palIdx), .cpalSel(cpalSel), .cpatIdx(cpatIdx), .rdData(rdData),
    .irq(irq), .palRgb(palRgb), .cpalRgb(cpalRgb), .cpatWord(cpatWord),
    .ctrlReg(ctrlReg), .depthBpp(depthBpp), .topOfScreen(topOfScreen),
    .cursorPos(cursorPos), .widthPx(widthPx), .heightPx(heightPx)
  );

  assign forceBlank = ctrlReg[10];
  assign cursorOff  = ctrlReg[23];
endmodule

// File: rtl/pixctl_regs_check.sv
module pixctl_regs_check #(
  parameter int DIM_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [20:0]      addr,
  input logic             wrEn,
  input logic             rdEn,
  input logic             frameTick,
  input logic [31:0]      rdData,
  input logic             rdValid,
  input logic             errPulse,
  input logic             irq,
  input logic [31:0]      ctrlReg,
  input logic [4:0]       depthBpp,
  input logic [DIM_W-1:0] widthPx,
  input logic [DIM_W-1:0] heightPx
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN) rdEn |=> rdValid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN) !rdEn |=> !rdValid); // R2
  AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN) wrEn |=> !irq); // R11
  AST_TICK_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN) (frameTick && !wrEn) |=> irq); // R11
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN) (rdValid && errPulse) |-> rdData == 32'h0); // R13
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN) (!rdEn && !wrEn) |=> !errPulse); // R13
  AST_WIDTH_ALIGNED: assert property (@(posedge clk) disable iff (!rstN) widthPx[1:0] == 2'b00); // R7
  AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    depthBpp inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16}); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN) !wrEn |=> $stable(ctrlReg)); // R8
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 21'h180000) |=> (ctrlReg == 32'h0 && widthPx == '0 && heightPx == '0 && !irq)); // R12
endmodule

bind pixctl_regs pixctl_regs_check #(.DIM_W(DIM_W)) u_chk (.*);

// File: tb/sim_pixctl_regs.sv
module sim_pixctl_regs;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [20:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, frameTick = 1'b0;
  logic [3:0] byteEn = 4'hF;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic rdValid, errPulse, irq, forceBlank, cursorOff;
  logic [7:0] palIdx = '0;
  logic [23:0] palRgb, cpalRgb;
  logic [1:0] cpalSel = '0;
  logic [8:0] cpatIdx = '0;
  logic [15:0] cpatWord, widthPx, heightPx;
  logic [31:0] ctrlReg, topOfScreen, cursorPos;
  logic [4:0] depthBpp;

  int nChk = 0, nBad = 0;
  logic lastErr;
  logic [31:0] rv;

  always #(CLK_P/2) clk = ~clk;

  pixctl_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); addr = a; wrData = d; byteEn = be; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; lastErr = errPulse;
  endtask

  task automatic rd(input logic [20:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk); addr = a; byteEn = be; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData; lastErr = errPulse;
    chk("R2 valid", {31'h0, rdValid}, 32'h1);
  endtask

  function automatic logic [4:0] expDepth(input int c);
    case (c)
      0: return 5'd1; 1: return 5'd2; 2: return 5'd4;
      3: return 5'd8; 4: return 5'd15; 5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    nBad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 ctrl", ctrlReg, 0);
    chk("R1 width", {16'h0, widthPx}, 0);
    chk("R1 pal", {8'h0, palRgb}, 0);
    chk("R1 rdValid", {31'h0, rdValid}, 0);
    chk("R1 err", {31'h0, errPulse}, 0);

    // R3 identifier and ignored addresses
    rd(21'h000000, 4'hF, rv); chk("R3 id", rv, 32'h10); chk("R3 id err", {31'h0, lastErr}, 0);
    wr(21'h080300, 32'h0012_3400, 4'hF);
    begin
      logic [20:0] ign [15] = '{21'h000000, 21'h080000, 21'h080108, 21'h080110, 21'h080120,
        21'h080128, 21'h080130, 21'h080138, 21'h080140, 21'h080148, 21'h080158,
        21'h080160, 21'h080168, 21'h080170, 21'h080200};
      for (int i = 0; i < 15; i++) begin
        wr(ign[i], 32'hFFFF_FFFF, 4'hF);
        chk("R3 ign err", {31'h0, lastErr}, 0);
        chk("R3 ign ctrl", ctrlReg, 32'h0012_3400);
        chk("R3 ign w", {16'h0, widthPx}, 0);
      end
    end
    rd(21'h000000, 4'hF, rv); chk("R3 id after wr", rv, 32'h10);

    // R4 colour table sweep
    for (int i = 0; i < 256; i++)
      wr(21'h080800 + 21'(i * 8), 32'hA500_0000 | ((i * 32'h0003_0507 + 32'h0011_2233) & 32'hFF_FFFF), 4'hF);
    for (int i = 0; i < 256; i++) begin
      palIdx = 8'(i); #1;
      chk("R4 pal", {8'h0, palRgb}, (i * 32'h0003_0507 + 32'h0011_2233) & 32'hFF_FFFF);
    end
    rd(21'h080808, 4'hF, rv); chk("R4 rd zero", rv, 0); chk("R4 rd err", {31'h0, lastErr}, 1);

    // R6 cursor bitmap sweep
    for (int i = 0; i < 512; i++)
      wr(21'h081000 + 21'(i * 8), {16'hBEEF, 16'(i * 37) ^ 16'h1234}, 4'hF);
    for (int i = 0; i < 512; i++) begin
      rd(21'h081000 + 21'(i * 8), 4'hF, rv);
      chk("R6 rd", rv, {16'h0, 16'(i * 37) ^ 16'h1234});
      cpatIdx = 9'(i); #1;
      chk("R6 port", {16'h0, cpatWord}, {16'h0, 16'(i * 37) ^ 16'h1234});
    end

    // R5 cursor palette
    for (int i = 0; i < 3; i++) wr(21'h080508 + 21'(i * 8), 32'hFF00_0000 | (32'h10_2030 * (i + 1)), 4'hF);
    for (int i = 0; i < 4; i++) begin
      cpalSel = 2'(i); #1;
      chk("R5 port", {8'h0, cpalRgb}, (i == 3) ? 0 : 32'h10_2030 * (i + 1));
    end
    rd(21'h08050C, 4'hF, rv); chk("R5 slot", rv, 32'h10_2030);
    rd(21'h080518, 4'hF, rv); chk("R5 rd", rv, 32'h30_6090);

    // R7 width and height scaling
    begin
      logic [31:0] vals [5] = '{32'h0, 32'h1, 32'h140, 32'h3FFF, 32'h5001};
      for (int i = 0; i < 5; i++) begin
        wr(21'h080118, vals[i], 4'hF);
        chk("R7 w", {16'h0, widthPx}, (vals[i] * 4) & 32'hFFFF);
        rd(21'h080118, 4'hF, rv); chk("R7 w rd", rv, ((vals[i] * 4) & 32'hFFFF) / 4);
        wr(21'h080150, vals[i] * 3, 4'hF);
        chk("R7 h", {16'h0, heightPx}, ((vals[i] * 3) / 2) & 32'hFFFF);
        rd(21'h080150, 4'hF, rv); chk("R7 h rd", rv, (((vals[i] * 3) / 2) & 32'hFFFF) * 2);
      end
    end

    // R8 depth decode
    for (int c = 0; c < 8; c++) begin
      wr(21'h080300, (32'(c) << 20) | (32'(c & 1) << 10) | (32'((c >> 1) & 1) << 23), 4'hF);
      chk("R8 depth", {27'h0, depthBpp}, {27'h0, expDepth(c)});
      chk("R8 blank", {31'h0, forceBlank}, 32'(c & 1));
      chk("R8 curoff", {31'h0, cursorOff}, 32'((c >> 1) & 1));
    end

    // R2 narrow reads, R10 narrow writes
    wr(21'h080300, 32'hA1B2_C3D4, 4'hF);
    for (int l = 0; l < 4; l++) begin
      rd(21'h080300 + 21'(l), 4'h1, rv);
      chk("R2 byte", rv, (32'hA1B2_C3D4 >> (8 * l)) & 32'hFF);
    end
    rd(21'h080300, 4'h3, rv); chk("R2 half lo", rv, 32'hC3D4);
    rd(21'h080302, 4'hC, rv); chk("R2 half hi", rv, 32'hA1B2);
    wr(21'h080301, 32'h0000_0077, 4'h1); chk("R10 byte ctrl", ctrlReg, 32'hA1B2_77D4);
    wr(21'h080302, 32'h0000_1357, 4'h3); chk("R10 half ctrl", ctrlReg, 32'h1357_77D4);
    wr(21'h080118, 32'h0000_0050, 4'hF);
    wr(21'h080119, 32'h0000_0001, 4'h1); chk("R10 width merge", {16'h0, widthPx}, 32'h0150 * 4);
    wr(21'h080808, 32'h0000_1234, 4'h3); palIdx = 8'd1; #1;
    chk("R10 pal merge", {8'h0, palRgb}, 32'h1234);

    // R9 write-only registers
    wr(21'h080400, 32'h1234_5678, 4'hF); chk("R9 top", topOfScreen, 32'h1234_5678);
    rd(21'h080400, 4'hF, rv); chk("R9 top rd", rv, 0); chk("R9 top err", {31'h0, lastErr}, 1);
    wr(21'h080401, 32'h0000_00AB, 4'h1); chk("R10 top merge", topOfScreen, 32'h0000_AB00);
    wr(21'h080638, 32'h0040_0020, 4'hF); chk("R9 cpos", cursorPos, 32'h0040_0020);
    rd(21'h080638, 4'hF, rv); chk("R9 cpos rd", rv, 0);

    // R13 unmapped
    rd(21'h040000, 4'hF, rv); chk("R13 rd zero", rv, 0); chk("R13 rd err", {31'h0, lastErr}, 1);
    @(negedge clk); chk("R13 err one cycle", {31'h0, errPulse}, 0);
    wr(21'h040000, 32'hFFFF_FFFF, 4'hF); chk("R13 wr err", {31'h0, lastErr}, 1);
    chk("R13 wr noeffect", ctrlReg, 32'h1357_77D4);

    // R11 interrupt
    @(negedge clk); frameTick = 1'b1; @(negedge clk); frameTick = 1'b0;
    chk("R11 set", {31'h0, irq}, 1);
    wr(21'h040000, 32'h0, 4'hF); chk("R11 clr undecoded", {31'h0, irq}, 0);
    @(negedge clk); frameTick = 1'b1; addr = 21'h080400; wrData = 32'h0; byteEn = 4'hF; wrEn = 1'b1;
    @(negedge clk); frameTick = 1'b0; wrEn = 1'b0;
    chk("R11 clear wins", {31'h0, irq}, 0);

    // R12 soft reset
    @(negedge clk); frameTick = 1'b1; @(negedge clk); frameTick = 1'b0;
    wr(21'h180000, 32'h0, 4'hF);
    chk("R12 irq", {31'h0, irq}, 0);
    chk("R12 ctrl", ctrlReg, 0);
    chk("R12 w", {16'h0, widthPx}, 0);
    chk("R12 h", {16'h0, heightPx}, 0);
    chk("R12 top", topOfScreen, 0);
    chk("R12 cpos", cursorPos, 0);
    palIdx = 8'd200; cpatIdx = 9'd300; cpalSel = 2'd2; #1;
    chk("R12 pal", {8'h0, palRgb}, 0);
    chk("R12 cpat", {16'h0, cpatWord}, 0);
    chk("R12 cpal", {8'h0, cpalRgb}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule